// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a small processor built around one accumulator. It fetches each instruction from memory at the address held in its program counter and places the opcode in an instruction register. It then executes the instruction against the accumulator and a four-bit condition register. Every instruction has the same three-byte shape: one opcode byte, then a 16-bit address sent low byte first. Each instruction takes exactly four clock cycles: three fetch cycles and one execute cycle.

The memory port has one address bus, one read strobe, one write strobe and one data bus in each direction. Read data must be valid in the same cycle as the address and `mem_rd`, as from an asynchronous-read memory. A write takes effect on the rising clock edge while `mem_wr` is high. Arithmetic and logic operations take their second operand from memory at the instruction's address and put the result back in the accumulator.

The instruction set has load, store, add, decrement, compare, AND and XOR. It has three kinds of one-bit shift (logical, arithmetic and rotate), each to the left or right. Program flow uses an unconditional jump, a branch on zero, a branch on plus, and halt. The halt state stops all activity until reset.

Top module: `acc_cpu_core`

## Requirements
- R1: After reset the program counter, accumulator and condition register are zero. The first fetch reads address 0 (`mem_rd`=1, `mem_wr`=0), `halted` is 0, and `flags` is 0. The `flags` port carries Z in bit 0, N in bit 1, C in bit 2 and G in bit 3.
- R2: Each instruction is an opcode byte followed by the address low byte and then the address high byte, read from consecutive locations. Every instruction takes four clock cycles, and unless it jumps, the next opcode is read three locations later.
- R3: LOAD (0x01) copies memory into the accumulator and sets Z and N from the loaded value. STORE (0x02) writes the accumulator to memory at the operand address and leaves every flag unchanged. The read and write strobes are never high together.
- R4: ADD (0x03) puts the accumulator plus the memory operand, modulo 256, into the accumulator. C is set to the unsigned carry out, and Z and N are set from the result. G is unchanged.
- R5: AND (0x06) and XOR (0x07) combine the accumulator with the memory operand bitwise. They set Z and N from the result and leave C and G unchanged.
- R6: DEC (0x04) subtracts one from the accumulator and ignores the address. It sets Z and N from the result and sets C only when the accumulator was 0 before the subtraction. A loop of DEC, branch-if-zero and jump stops after N passes when the accumulator starts at N.
- R7: CMP (0x05) compares the accumulator with the memory operand as unsigned numbers. It sets Z when they are equal, G when the accumulator is greater and C when it is smaller. N and the accumulator are unchanged.
- R8: LSL (0x08) and LSR (0x09) shift the accumulator one bit and put 0 into the vacated bit. C receives the bit shifted out, Z and N follow the result, and the address is ignored.
- R9: ASL (0x0A) shifts left and copies the old bit 0 into bit 0. ASR (0x0B) shifts right and copies the old bit 7 into bit 7. C receives the bit shifted out, and Z and N follow the result.
- R10: ROL (0x0C) and ROR (0x0D) rotate the accumulator one bit, so the bit leaving one end enters at the other. That bit also goes to C, and Z and N follow the result.
- R11: JMP (0x0E) always loads the program counter with the operand address. BZ (0x0F) does so only when Z=1, and BPL (0x10) does so only when N=0. A branch that is not taken continues with the next instruction.
- R12: HALT (0xFF) raises `halted`. After that, `mem_rd` and `mem_wr` stay low and `halted` stays high until reset.
- R13: Any other opcode executes as a four-cycle no-operation. It changes neither memory, the accumulator nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory address for a fetch or an operand access |
| mem_rd | output | 1 | Read strobe; data is taken from `mem_rdata` in the same cycle |
| mem_wr | output | 1 | Write strobe; memory stores `mem_wdata` at the rising edge |
| mem_wdata | output | 8 | Store data (accumulator) |
| mem_rdata | input | 8 | Read data from memory |
| flags | output | 4 | Condition register {G, C, N, Z} |
| halted | output | 1 | High once a HALT has executed |

## Verification
Most internal faults appear at the ports within one instruction, or four cycles. A wrong accumulator shows up in the byte written by the next STORE. A wrong flag shows up directly on `flags`, or in which path a following branch takes. A wrong program counter or fetch sequence changes the address stream and the cycle count to `halted`. That count is checked exactly against the number of instructions times four. A halt state that does not hold is visible the cycle after it fails, as bus strobes that should have stayed low.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [2:0] {
      ST_FETCH_OP,
      ST_ADDR_LO,
      ST_ADDR_HI,
      ST_EXEC,
      ST_HALTED
   } state_t;

   typedef enum logic [3:0] {
      ALU_PASS,
      ALU_LOAD,
      ALU_ADD,
      ALU_DEC,
      ALU_CMP,
      ALU_AND,
      ALU_XOR,
      ALU_LSL,
      ALU_LSR,
      ALU_ASL,
      ALU_ASR,
      ALU_ROL,
      ALU_ROR
   } alu_op_t;

   // bit 3..0 = G, C, N, Z
   typedef struct packed {
      logic g;
      logic c;
      logic n;
      logic z;
   } flags_t;

   localparam int unsigned OPC_LOAD  = 'h01;
   localparam int unsigned OPC_STORE = 'h02;
   localparam int unsigned OPC_ADD   = 'h03;
   localparam int unsigned OPC_DEC   = 'h04;
   localparam int unsigned OPC_CMP   = 'h05;
   localparam int unsigned OPC_AND   = 'h06;
   localparam int unsigned OPC_XOR   = 'h07;
   localparam int unsigned OPC_LSL   = 'h08;
   localparam int unsigned OPC_LSR   = 'h09;
   localparam int unsigned OPC_ASL   = 'h0A;
   localparam int unsigned OPC_ASR   = 'h0B;
   localparam int unsigned OPC_ROL   = 'h0C;
   localparam int unsigned OPC_ROR   = 'h0D;
   localparam int unsigned OPC_JMP   = 'h0E;
   localparam int unsigned OPC_BZ    = 'h0F;
   localparam int unsigned OPC_BPL   = 'h10;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] ir,
   output alu_op_t           alu_op,
   output logic              rd_oper,
   output logic              wr_oper,
   output logic              is_jmp,
   output logic              is_bz,
   output logic              is_bpl,
   output logic              is_halt
);

   always_comb begin
      alu_op  = ALU_PASS;
      rd_oper = 1'b0;
      wr_oper = 1'b0;
      is_jmp  = 1'b0;
      is_bz   = 1'b0;
      is_bpl  = 1'b0;
      is_halt = (ir == {DATA_W{1'b1}});
      case (ir)
         DATA_W'(OPC_LOAD):  begin alu_op = ALU_LOAD; rd_oper = 1'b1; end
         DATA_W'(OPC_STORE): wr_oper = 1'b1;
         DATA_W'(OPC_ADD):   begin alu_op = ALU_ADD;  rd_oper = 1'b1; end
         DATA_W'(OPC_DEC):   alu_op = ALU_DEC;
         DATA_W'(OPC_CMP):   begin alu_op = ALU_CMP;  rd_oper = 1'b1; end
         DATA_W'(OPC_AND):   begin alu_op = ALU_AND;  rd_oper = 1'b1; end
         DATA_W'(OPC_XOR):   begin alu_op = ALU_XOR;  rd_oper = 1'b1; end
         DATA_W'(OPC_LSL):   alu_op = ALU_LSL;
         DATA_W'(OPC_LSR):   alu_op = ALU_LSR;
         DATA_W'(OPC_ASL):   alu_op = ALU_ASL;
         DATA_W'(OPC_ASR):   alu_op = ALU_ASR;
         DATA_W'(OPC_ROL):   alu_op = ALU_ROL;
         DATA_W'(OPC_ROR):   alu_op = ALU_ROR;
         DATA_W'(OPC_JMP):   is_jmp = 1'b1;
         DATA_W'(OPC_BZ):    is_bz  = 1'b1;
         DATA_W'(OPC_BPL):   is_bpl = 1'b1;
         default:            ;
      endcase
   end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit SIGNED_CMP = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_op_t           op,
   input  flags_t            fin,
   output logic [DATA_W-1:0] res,
   output flags_t            fout
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0] sum;
   logic            a_gt_b;
   logic            a_lt_b;

   assign sum = {1'b0, a} + {1'b0, b};

   generate
      if (SIGNED_CMP) begin : g_cmp_signed
         assign a_gt_b = $signed(a) > $signed(b);
         assign a_lt_b = $signed(a) < $signed(b);
      end else begin : g_cmp_unsigned
         assign a_gt_b = a > b;
         assign a_lt_b = a < b;
      end
   endgenerate

   always_comb begin
      res  = a;
      fout = fin;
      case (op)
         ALU_LOAD: res = b;
         ALU_ADD:  begin res = sum[MSB:0];        fout.c = sum[DATA_W]; end
         ALU_DEC:  begin res = a - 1'b1;          fout.c = (a == '0);   end
         ALU_AND:  res = a & b;
         ALU_XOR:  res = a ^ b;
         ALU_LSL:  begin res = {a[MSB-1:0], 1'b0};   fout.c = a[MSB]; end
         ALU_LSR:  begin res = {1'b0, a[MSB:1]};     fout.c = a[0];   end
         ALU_ASL:  begin res = {a[MSB-1:0], a[0]};   fout.c = a[MSB]; end
         ALU_ASR:  begin res = {a[MSB], a[MSB:1]};   fout.c = a[0];   end
         ALU_ROL:  begin res = {a[MSB-1:0], a[MSB]}; fout.c = a[MSB]; end
         ALU_ROR:  begin res = {a[0], a[MSB:1]};     fout.c = a[0];   end
         ALU_CMP:  begin
            fout.z = (a == b);
            fout.g = a_gt_b;
            fout.c = a_lt_b;
         end
         default:  ;
      endcase
      if (op != ALU_PASS && op != ALU_CMP) begin
         fout.z = (res == '0);
         fout.n = res[MSB];
      end
   end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rdata,
   input  logic              take_jump,
   input  logic              halt_op,
   output state_t            state,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] ir,
   output logic [ADDR_W-1:0] oper
);

   localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_FETCH_OP;
         pc    <= '0;
         ir    <= '0;
         oper  <= '0;
      end else begin
         case (state)
            ST_FETCH_OP: begin
               ir    <= rdata;
               pc    <= pc + PC_ONE;
               state <= ST_ADDR_LO;
            end
            ST_ADDR_LO: begin
               oper[DATA_W-1:0] <= rdata;
               pc    <= pc + PC_ONE;
               state <= ST_ADDR_HI;
            end
            ST_ADDR_HI: begin
               oper[ADDR_W-1:DATA_W] <= rdata;
               pc    <= pc + PC_ONE;
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               if (take_jump) pc <= oper;
               state <= halt_op ? ST_HALTED : ST_FETCH_OP;
            end
            default: state <= ST_HALTED;
         endcase
      end
   end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 16,
   parameter bit SIGNED_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [3:0]        flags,
   output logic              halted
);

   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("acc_cpu_core: DATA_W must be at least 8");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr_w
         $error("acc_cpu_core: ADDR_W must equal two data bytes");
      end
   endgenerate

   state_t            state;
   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] oper;
   logic [DATA_W-1:0] ir;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] alu_res;
   flags_t            flg;
   flags_t            alu_flg;
   alu_op_t           alu_op;
   logic              rd_oper, wr_oper, is_jmp, is_bz, is_bpl, is_halt;
   logic              in_fetch, in_exec, take_jump;

   acc_cpu_decode #(.DATA_W(DATA_W)) u_dec (
      .ir(ir), .alu_op(alu_op), .rd_oper(rd_oper), .wr_oper(wr_oper),
      .is_jmp(is_jmp), .is_bz(is_bz), .is_bpl(is_bpl), .is_halt(is_halt)
   );

   acc_cpu_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .rdata(mem_rdata), .take_jump(take_jump),
      .halt_op(is_halt), .state(state), .pc(pc), .ir(ir), .oper(oper)
   );

   acc_cpu_alu #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) u_alu (
      .a(acc), .b(mem_rdata), .op(alu_op), .fin(flg), .res(alu_res), .fout(alu_flg)
   );

   assign in_fetch  = (state == ST_FETCH_OP) || (state == ST_ADDR_LO) || (state == ST_ADDR_HI);
   assign in_exec   = (state == ST_EXEC);
   assign take_jump = in_exec && (is_jmp || (is_bz && flg.z) || (is_bpl && !flg.n));

   assign mem_addr  = in_exec ? oper : pc;
   assign mem_rd    = in_fetch || (in_exec && rd_oper);
   assign mem_wr    = in_exec && wr_oper;
   assign mem_wdata = acc;
   assign flags     = flg;
   assign halted    = (state == ST_HALTED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         flg <= '0;
      end else if (in_exec) begin
         acc <= alu_res;
         flg <= alu_flg;
      end
   end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input state_t            state,
   input logic [ADDR_W-1:0] pc,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [3:0]        flags,
   input logic              halted
);

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH_OP) |=> (pc == $past(pc) + 1'b1)); // R2
   AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH_OP) |=> (state == ST_ADDR_LO)); // R2
   AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R3
   AST_WR_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (state == ST_EXEC)); // R3
   AST_STORE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> $stable(flags)); // R3
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R12
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_rd && !mem_wr)); // R12

endmodule

bind acc_cpu_core acc_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .state(state), .pc(pc), .mem_rd(mem_rd),
   .mem_wr(mem_wr), .flags(flags), .halted(halted)
);

// File: tb/acc_cpu_core_test.sv
module acc_cpu_core_test;

   localparam logic [7:0] O_LD = 8'h01, O_ST = 8'h02, O_ADD = 8'h03, O_DEC = 8'h04,
                          O_CMP = 8'h05, O_AND = 8'h06, O_XOR = 8'h07, O_LSL = 8'h08,
                          O_LSR = 8'h09, O_ASL = 8'h0A, O_ASR = 8'h0B, O_ROL = 8'h0C,
                          O_ROR = 8'h0D, O_JMP = 8'h0E, O_BZ = 8'h0F, O_BPL = 8'h10,
                          O_HLT = 8'hFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, halted;
   logic [7:0]  mem_wdata, mem_rdata;
   logic [3:0]  flags;
   logic [7:0]  prog [0:255];
   logic [7:0]  mem  [0:255];
   int          ntests = 0;
   int          nfail = 0;
   int          ptr;
   bit          first_run = 1'b1;

   always #5 clk = ~clk;

   acc_cpu_core uut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .flags(flags), .halted(halted)
   );

   assign mem_rdata = mem[mem_addr[7:0]];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= prog[i];
      end else if (mem_wr) begin
         mem[mem_addr[7:0]] <= mem_wdata;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      ntests++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] ref_step(input logic [7:0] op, input logic [7:0] a,
                                            input logic [7:0] b, input logic [3:0] f);
      logic [7:0] r;
      logic [3:0] nf;
      logic [8:0] s;
      r  = a;
      nf = f;
      s  = {1'b0, a} + {1'b0, b};
      case (op)
         O_LD:  r = b;
         O_ADD: begin r = s[7:0]; nf[2] = s[8]; end
         O_DEC: begin r = a - 8'd1; nf[2] = (a == 8'd0); end
         O_AND: r = a & b;
         O_XOR: r = a ^ b;
         O_LSL: begin r = {a[6:0], 1'b0}; nf[2] = a[7]; end
         O_LSR: begin r = {1'b0, a[7:1]}; nf[2] = a[0]; end
         O_ASL: begin r = {a[6:0], a[0]}; nf[2] = a[7]; end
         O_ASR: begin r = {a[7], a[7:1]}; nf[2] = a[0]; end
         O_ROL: begin r = {a[6:0], a[7]}; nf[2] = a[7]; end
         O_ROR: begin r = {a[0], a[7:1]}; nf[2] = a[0]; end
         O_CMP: begin nf[0] = (a == b); nf[3] = (a > b); nf[2] = (a < b); end
         default: ;
      endcase
      if (op inside {O_LD, O_ADD, O_DEC, O_AND, O_XOR, O_LSL, O_LSR, O_ASL, O_ASR, O_ROL, O_ROR}) begin
         nf[0] = (r == 8'd0);
         nf[1] = r[7];
      end
      return {nf, r};
   endfunction

   function automatic string op_req(input logic [7:0] op);
      case (op)
         O_LD:           return "R3";
         O_ADD:          return "R4";
         O_AND, O_XOR:   return "R5";
         O_DEC:          return "R6";
         O_CMP:          return "R7";
         O_LSL, O_LSR:   return "R8";
         O_ASL, O_ASR:   return "R9";
         O_ROL, O_ROR:   return "R10";
         default:        return "R13";
      endcase
   endfunction

   task automatic clear_prog();
      for (int i = 0; i < 256; i++) prog[i] = O_HLT;
      ptr = 0;
   endtask

   task automatic emit(input logic [7:0] op, input logic [15:0] addr);
      prog[ptr]     = op;
      prog[ptr + 1] = addr[7:0];
      prog[ptr + 2] = addr[15:8];
      ptr += 3;
   endtask

   task automatic run_prog(output int cycles);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      if (first_run) begin
         chk("R1 addr", 32'(mem_addr), 32'h0);
         chk("R1 rd", 32'(mem_rd), 32'h1);
         chk("R1 wr", 32'(mem_wr), 32'h0);
         chk("R1 halted", 32'(halted), 32'h0);
         chk("R1 flags", 32'(flags), 32'h0);
         first_run = 1'b0;
      end
      cycles = 0;
      while (1) begin
         @(posedge clk);
         cycles++;
         @(negedge clk);
         if (halted) break;
         if (cycles > 2000) begin
            chk("R12 halt not reached", 32'(cycles), 32'h0);
            break;
         end
      end
   endtask

   task automatic do_alu(input logic [7:0] op, input logic [7:0] p, input logic [7:0] q,
                         input logic [7:0] a, input logic [7:0] b);
      logic [11:0] st;
      int cyc;
      clear_prog();
      emit(O_LD, 16'h0080);
      emit(O_CMP, 16'h0081);
      emit(O_LD, 16'h0082);
      emit(op, 16'h0083);
      emit(O_ST, 16'h0090);
      emit(O_HLT, 16'h0000);
      prog[8'h80] = p; prog[8'h81] = q; prog[8'h82] = a; prog[8'h83] = b; prog[8'h90] = 8'h5A;
      st = ref_step(O_LD, 8'h00, p, 4'h0);
      st = ref_step(O_CMP, st[7:0], q, st[11:8]);
      st = ref_step(O_LD, st[7:0], a, st[11:8]);
      st = ref_step(op, st[7:0], b, st[11:8]);
      run_prog(cyc);
      chk({op_req(op), " result"}, 32'(mem[8'h90]), 32'(st[7:0]));
      chk({op_req(op), " flags"}, 32'(flags), 32'(st[11:8]));
      chk("R2 cycles", 32'(cyc), 32'd24);
   endtask

   task automatic do_branch(input logic [7:0] bop, input logic [7:0] v, input bit taken);
      int cyc;
      clear_prog();
      emit(O_LD, 16'h0080);
      emit(bop, 16'd15);
      emit(O_LD, 16'h0081);
      emit(O_ST, 16'h0090);
      emit(O_HLT, 16'h0000);
      emit(O_LD, 16'h0082);
      emit(O_ST, 16'h0090);
      emit(O_HLT, 16'h0000);
      prog[8'h80] = v; prog[8'h81] = 8'd1; prog[8'h82] = 8'd2;
      run_prog(cyc);
      chk("R11 branch path", 32'(mem[8'h90]), taken ? 32'd2 : 32'd1);
      chk("R11 cycles", 32'(cyc), 32'd20);
   endtask

   logic [7:0] ops [12] = '{O_LD, O_ADD, O_DEC, O_CMP, O_AND, O_XOR,
                            O_LSL, O_LSR, O_ASL, O_ASR, O_ROL, O_ROR};
   logic [7:0] corners [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};

   initial begin
      #1_900_000;
      nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

   initial begin
      int cyc;
      void'($urandom(32'd20241));
      clear_prog();
      // directed corners: every ALU op across edge values
      foreach (ops[i]) begin
         foreach (corners[j]) begin
            do_alu(ops[i], corners[j], corners[4 - j], corners[j], corners[(j + 2) % 5]);
         end
      end
      // R9 sign fill with negative accumulator
      do_alu(O_ASR, 8'h00, 8'h00, 8'h81, 8'h00);
      chk("R9 asr sign", 32'(mem[8'h90]), 32'h0C0);
      // random stimulus
      for (int k = 0; k < 80; k++) begin
         do_alu(ops[$urandom % 12], 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      end
      // R11 branches and jump
      do_branch(O_BZ,  8'h00, 1'b1);
      do_branch(O_BZ,  8'h05, 1'b0);
      do_branch(O_BPL, 8'h7F, 1'b1);
      do_branch(O_BPL, 8'h80, 1'b0);
      do_branch(O_BPL, 8'h00, 1'b1);
      do_branch(O_JMP, 8'h80, 1'b1);
      // R6 decrement loop, then R12 halt quiet
      for (int n = 1; n <= 6; n += 5) begin
         clear_prog();
         emit(O_LD, 16'h0080);
         emit(O_DEC, 16'h0000);
         emit(O_BZ, 16'd12);
         emit(O_JMP, 16'd3);
         emit(O_ST, 16'h0090);
         emit(O_HLT, 16'h0000);
         prog[8'h80] = 8'(n); prog[8'h90] = 8'hEE;
         run_prog(cyc);
         chk("R6 loop result", 32'(mem[8'h90]), 32'h0);
         chk("R6 loop cycles", 32'(cyc), 32'(4 * (3 * n + 2)));
      end
      for (int t = 0; t < 8; t++) begin
         @(negedge clk);
         chk("R12 halted held", 32'(halted), 32'h1);
         chk("R12 bus idle", 32'({mem_rd, mem_wr}), 32'h0);
      end
      // R13 unknown opcode is a no-op
      clear_prog();
      emit(O_LD, 16'h0080);
      emit(8'h20, 16'h0090);
      emit(8'h77, 16'h0091);
      emit(O_ST, 16'h0092);
      emit(O_HLT, 16'h0000);
      prog[8'h80] = 8'h93; prog[8'h90] = 8'hA5; prog[8'h91] = 8'h3C;
      run_prog(cyc);
      chk("R13 mem untouched", 32'({mem[8'h90], mem[8'h91]}), 32'hA53C);
      chk("R13 acc kept", 32'(mem[8'h92]), 32'h93);
      chk("R13 flags kept", 32'(flags), 32'h2);
      chk("R13 cycles", 32'(cyc), 32'd20);
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

endmodule